// File: doc/BRIEF.md
# Interrupt Enable and Pending Register Pair

This block holds two 32-bit registers for a peripheral's interrupt sources: an enable mask and a pending-flag word. Software reaches them over a simple single-cycle memory-mapped port with an address, a write strobe, write data and read data. Neither register is written directly. Each one has a write-ones-to-set alias and a write-ones-to-clear alias, so a service routine can change one bit without a read-modify-write sequence.

The pending flags are set in two ways: by one-cycle hardware event pulses, or by software writing ones to the flag-set alias, which lets software inject a test interrupt. Software writes ones to the flag-clear alias to acknowledge a request. A single registered request line goes high whenever any source is both pending and enabled.

Top module: `irq_regpair`

## Requirements
- R1: After synchronous reset, the enable word and the flag word are both zero and the request output is low.
- R2: A write to the enable-set alias (word offset 1) sets every enable bit whose write-data bit is one and leaves all other enable bits unchanged.
- R3: A write to the enable-clear alias (word offset 2) clears every enable bit whose write-data bit is one and leaves all other enable bits unchanged.
- R4: A one-cycle pulse on an event input bit sets the matching flag bit. A flag that is already set stays set, and events are not counted.
- R5: A write to the flag-set alias (word offset 4) sets every flag bit whose write-data bit is one.
- R6: A write to the flag-clear alias (word offset 5) clears every flag bit whose write-data bit is one. If an event pulse and a clear hit the same bit in the same cycle, the bit stays set.
- R7: Writes to the enable base (offset 0), the flag base (offset 3) or any unmapped offset change neither register.
- R8: Reads return the enable word at offset 0 and the flag word at offset 3. Reads of the four alias offsets and of unmapped offsets return zero. Read data is combinational from the current register state.
- R9: The request output is high in the cycle after any bit position has both its flag and its enable at one, and low in the cycle after no such position remains.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Word offset of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| evt_pulse | input | 32 | One-cycle hardware event pulses, one per source |
| irq_req | output | 1 | Registered interrupt request |

## Verification
A wrong bit in the enable or flag word shows at the read port in the cycle after the access that caused it, because reads are combinational. The bench reads both bases after each scenario, and its model is compared with the read data on every cycle. A wrong request term shows on irq_req exactly one clock after the state changes. The same-cycle event and clear collision and the writes to read-only bases are driven on purpose, so a lost event or a write that should have been ignored shows up at once.

// File: rtl/irq_regpair_pkg.sv
package irq_regpair_pkg;
    localparam int SRC_W  = 32;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        OFS_EN_BASE  = 3'd0,
        OFS_EN_SET   = 3'd1,
        OFS_EN_CLR   = 3'd2,
        OFS_FL_BASE  = 3'd3,
        OFS_FL_SET   = 3'd4,
        OFS_FL_CLR   = 3'd5
    } reg_ofs_e;

    typedef struct packed {
        logic [SRC_W-1:0] set_mask;
        logic [SRC_W-1:0] clr_mask;
    } upd_t;

    function automatic logic [SRC_W-1:0] apply_upd(
        input logic [SRC_W-1:0] cur,
        input upd_t             u
    );
        return (cur & ~u.clr_mask) | u.set_mask;
    endfunction
endpackage

// File: rtl/irq_decode.sv
module irq_decode
    import irq_regpair_pkg::*;
#(
    parameter int W  = SRC_W,
    parameter int AW = ADDR_W
) (
    input  logic [AW-1:0] addr,
    input  logic          we,
    input  logic [W-1:0]  wdata,
    input  logic [W-1:0]  evt,
    output upd_t          en_upd,
    output upd_t          fl_upd
);
    always_comb begin
        en_upd = '0;
        fl_upd = '0;
        fl_upd.set_mask = evt;
        if (we) begin
            unique case (addr)
                OFS_EN_SET: en_upd.set_mask = wdata;
                OFS_EN_CLR: en_upd.clr_mask = wdata;
                OFS_FL_SET: fl_upd.set_mask = evt | wdata;
                OFS_FL_CLR: fl_upd.clr_mask = wdata;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/irq_bitreg.sv
module irq_bitreg
    import irq_regpair_pkg::*;
#(
    parameter int W = SRC_W
) (
    input  logic         clk,
    input  logic         rst,
    input  upd_t         upd,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                q[i] <= 1'b0;
            else if (upd.set_mask[i])
                q[i] <= 1'b1;
            else if (upd.clr_mask[i])
                q[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_regpair.sv
module irq_regpair
    import irq_regpair_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [SRC_W-1:0]  bus_wdata,
    output logic [SRC_W-1:0]  bus_rdata,
    input  logic [SRC_W-1:0]  evt_pulse,
    output logic              irq_req
);
    upd_t             en_upd, fl_upd;
    logic [SRC_W-1:0] en_q, fl_q;

    irq_decode #(.W(SRC_W), .AW(ADDR_W)) u_dec (
        .addr(bus_addr), .we(bus_we), .wdata(bus_wdata), .evt(evt_pulse),
        .en_upd(en_upd), .fl_upd(fl_upd)
    );

    irq_bitreg #(.W(SRC_W)) u_en (.clk(clk), .rst(rst), .upd(en_upd), .q(en_q));
    irq_bitreg #(.W(SRC_W)) u_fl (.clk(clk), .rst(rst), .upd(fl_upd), .q(fl_q));

    always_comb begin
        unique case (bus_addr)
            OFS_EN_BASE: bus_rdata = en_q;
            OFS_FL_BASE: bus_rdata = fl_q;
            default:     bus_rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) irq_req <= 1'b0;
        else     irq_req <= |(en_q & fl_q);
    end
endmodule

// File: rtl/irq_regpair_chk.sv
module irq_regpair_chk
    import irq_regpair_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [SRC_W-1:0]  bus_wdata,
    input logic [SRC_W-1:0]  evt_pulse,
    input logic [SRC_W-1:0]  en_q,
    input logic [SRC_W-1:0]  fl_q,
    input logic              irq_req
);
    AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (en_q == '0 && fl_q == '0 && !irq_req)); // R1
    AST_EN_SET: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == OFS_EN_SET) |=> ((en_q & $past(bus_wdata)) == $past(bus_wdata))); // R2
    AST_EN_CLR: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == OFS_EN_CLR) |=> ((en_q & $past(bus_wdata)) == '0)); // R3
    AST_EVT_SETS: assert property (@(posedge clk) disable iff (rst)
        (evt_pulse != '0) |=> ((fl_q & $past(evt_pulse)) == $past(evt_pulse))); // R4
    AST_FL_SET: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == OFS_FL_SET) |=> ((fl_q & $past(bus_wdata)) == $past(bus_wdata))); // R5
    AST_FL_CLR: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == OFS_FL_CLR) |=> ((fl_q & $past(bus_wdata) & ~$past(evt_pulse)) == '0)); // R6
    AST_RO_EN: assert property (@(posedge clk) disable iff (rst)
        (!(bus_we && (bus_addr == OFS_EN_SET || bus_addr == OFS_EN_CLR))) |=> $stable(en_q)); // R7
    AST_IRQ: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_req == ($past(en_q & fl_q) != '0))); // R9
endmodule

bind irq_regpair irq_regpair_chk u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .evt_pulse(evt_pulse),
    .en_q(en_q), .fl_q(fl_q), .irq_req(irq_req)
);

// File: tb/irq_regpair_tb.sv
module irq_regpair_tb;
    logic        clk = 0;
    logic        rst = 1;
    logic [2:0]  bus_addr = 0;
    logic        bus_we = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] evt_pulse = 0;
    logic [31:0] bus_rdata;
    logic        irq_req;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [31:0] m_en = 0, m_fl = 0;
    logic        m_irq = 0;

    irq_regpair u_dut (.*);

    always #10 clk = ~clk;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] m_read(logic [2:0] a);
        if (a == 3'd0) return m_en;
        if (a == 3'd3) return m_fl;
        return 32'h0;
    endfunction

    // behavioural model, updated at each clock edge
    always @(posedge clk) begin
        logic [31:0] ne, nf;
        if (rst) begin
            m_en <= 0; m_fl <= 0; m_irq <= 0;
        end else begin
            ne = m_en; nf = m_fl;
            if (bus_we) begin
                case (bus_addr)
                    3'd1: ne = ne | bus_wdata;
                    3'd2: ne = ne & ~bus_wdata;
                    3'd4: nf = nf | bus_wdata;
                    3'd5: nf = nf & ~bus_wdata;
                    default: ;
                endcase
            end
            nf = nf | evt_pulse;
            m_irq <= (m_en & m_fl) != 0;
            m_en <= ne; m_fl <= nf;
        end
    end

    // per-cycle comparison away from the edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R8 rdata", bus_rdata, m_read(bus_addr));
            check("R9 irq", {31'b0, irq_req}, {31'b0, m_irq});
        end
    end

    task automatic wr(logic [2:0] a, logic [31:0] d, logic [31:0] e = 0);
        @(negedge clk);
        bus_addr = a; bus_we = 1; bus_wdata = d; evt_pulse = e;
        @(negedge clk);
        bus_we = 0; bus_wdata = 0; evt_pulse = 0;
    endtask

    task automatic rd(string req, logic [2:0] a, logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1 check(req, bus_rdata, exp);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;
        rd("R1 en reset", 3'd0, 32'h0);
        rd("R1 fl reset", 3'd3, 32'h0);
        check("R1 irq reset", {31'b0, irq_req}, 32'h0);

        wr(3'd1, 32'h0000_00F0);
        rd("R2 en set", 3'd0, 32'h0000_00F0);
        wr(3'd1, 32'h8000_0001);
        rd("R2 en set keeps", 3'd0, 32'h8000_00F1);
        wr(3'd2, 32'h0000_0030);
        rd("R3 en clr", 3'd0, 32'h8000_00C1);

        wr(3'd0, 32'hFFFF_FFFF);
        rd("R7 en base ro", 3'd0, 32'h8000_00C1);
        wr(3'd3, 32'hFFFF_FFFF);
        rd("R7 fl base ro", 3'd3, 32'h0);
        wr(3'd6, 32'hFFFF_FFFF);
        wr(3'd7, 32'hFFFF_FFFF);
        rd("R7 unmapped en", 3'd0, 32'h8000_00C1);
        rd("R7 unmapped fl", 3'd3, 32'h0);

        rd("R8 alias en set reads 0", 3'd1, 32'h0);
        rd("R8 alias en clr reads 0", 3'd2, 32'h0);
        rd("R8 alias fl set reads 0", 3'd4, 32'h0);
        rd("R8 alias fl clr reads 0", 3'd5, 32'h0);

        @(negedge clk) evt_pulse = 32'h0000_0100;
        @(negedge clk) evt_pulse = 32'h0000_0100;
        @(negedge clk) evt_pulse = 0;
        rd("R4 event sets", 3'd3, 32'h0000_0100);
        check("R9 masked no irq", {31'b0, irq_req}, 32'h0);

        wr(3'd4, 32'h0000_0040);
        rd("R5 fl set", 3'd3, 32'h0000_0140);
        @(negedge clk);
        check("R9 irq high", {31'b0, irq_req}, 32'h1);

        wr(3'd5, 32'h0000_0140, 32'h0000_0100);
        rd("R6 collision event wins", 3'd3, 32'h0000_0100);
        @(negedge clk);
        check("R9 irq low", {31'b0, irq_req}, 32'h0);
        wr(3'd5, 32'h0000_0100);
        rd("R6 fl clr", 3'd3, 32'h0);

        wr(3'd4, 32'h8000_0000);
        wr(3'd2, 32'hFFFF_FFFF);
        rd("R3 en clr all", 3'd0, 32'h0);
        repeat (2) @(negedge clk);
        check("R9 irq after disable", {31'b0, irq_req}, 32'h0);

        @(negedge clk) rst = 1;
        @(negedge clk) rst = 0;
        rd("R1 fl after reset", 3'd3, 32'h0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule